// File: doc/BRIEF.md
# System Instruction Privilege Trap Checker

This block decides, for a small family of privileged system instructions, whether the instruction traps and, if it does, with which exception. The instructions covered are: wait-for-interrupt, wait-on-reservation without timeout, the address-translation fence, the two hypervisor fences (guest-virtual and guest-physical), and the hypervisor guest load, store and execute-permission load. The decode stage of the hart presents an opcode class together with the current privilege level, the virtualization flag and the relevant trap-control bits from the machine and hypervisor status registers. The trap logic downstream uses the result.

The decision is made in one combinational pass and held in a single output register stage, so every input vector's verdict appears on the outputs one clock after it is sampled. Besides the exception code, the block issues a halt request for wait-for-interrupt and a flush request for the fences, and for hypervisor accesses it reports the translation-mode index that the memory pipeline must use. Within each instruction the checks are resolved in a fixed priority, and a request is never issued alongside an exception.

Top module: `sysins_trap_chk`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, exc is 0, halt_req and flush_req are 0 and xlat_idx is 0.
- R2: Wait-for-interrupt (op_class 1) reports illegal instruction (exc=1) when tw=1 and either priv is supervisor (1) or priv is user (0) with has_smode=0, or when has_smode=1, priv is user and virt=0.
- R3: When R2 does not apply, a virtualized wait-for-interrupt reports virtual instruction (exc=2) if priv is user, or if priv is supervisor with vtw=1; otherwise halt_req is 1 with exc=0.
- R4: Wait-on-reservation (op_class 2) reports virtual instruction when virt=1, priv is user or supervisor, vtw=1 and tw=0; otherwise illegal instruction when priv is not machine (3) and tw=1; otherwise no exception and no request.
- R5: The translation fence (op_class 3) with virt=0 is illegal when priv is user, or supervisor with tvm=1; with virt=1 it is a virtual instruction fault when priv is user or vtvm=1; otherwise flush_req is 1.
- R6: The hypervisor fences (op_class 4 guest-virtual, 5 guest-physical) raise virtual instruction when virt=1, flush in machine mode or non-virtualized supervisor mode, and are illegal otherwise; op_class 5 additionally is illegal in non-virtualized supervisor mode with tvm=1.
- R7: Hypervisor accesses (op_class 6 load, 7 store, 8 execute-permission load) never trap in machine mode; otherwise virt=1 gives virtual instruction, and priv user with hu=0 gives illegal instruction.
- R8: For op_class 6 to 8, xlat_idx bit 2 (two-stage flag) is always 1 and bits 1:0 are spvp (0 user, 1 supervisor), replaced by 2 (supervisor with user-page access) when the op is 6 or 7, spvp=1 and vs_sum=1; for all other op classes xlat_idx is 0.
- R9: Op classes 0 and 9 to 15 produce exc=0, no request and xlat_idx=0.
- R10: halt_req and flush_req are 0 in every cycle where exc is non-zero, and every output reflects the inputs sampled at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_class | input | 4 | Instruction class (see R2 to R9) |
| priv | input | 2 | Privilege: 0 user, 1 supervisor, 3 machine |
| virt | input | 1 | Virtualization active |
| has_smode | input | 1 | Supervisor mode implemented |
| tw | input | 1 | Machine status: trap wait |
| tvm | input | 1 | Machine status: trap translation management |
| vtw | input | 1 | Hypervisor status: trap guest wait |
| vtvm | input | 1 | Hypervisor status: trap guest translation management |
| hu | input | 1 | Hypervisor status: user-mode hypervisor access allowed |
| spvp | input | 1 | Hypervisor status: previous guest privilege (0 user, 1 supervisor) |
| vs_sum | input | 1 | Guest supervisor status: user-page access permitted |
| exc | output | 2 | 0 none, 1 illegal instruction, 2 virtual instruction |
| halt_req | output | 1 | Halt request for wait-for-interrupt |
| flush_req | output | 1 | Translation cache flush request |
| xlat_idx | output | 3 | Translation-mode index for hypervisor accesses |

## Verification
The functions that meet in one cycle are the request outputs (halt or flush) and the exception code: a vector that would flush or halt under one set of control bits traps under a neighbouring one, and the two must never appear together. The bench provokes this by sweeping every op class against every legal privilege and every combination of the nine control bits, one vector per clock, so each vector's verdict lands in the cycle directly after a different vector's. A behavioural model computes the expected exception, request and index for each vector, and the registered outputs are compared one clock later.

// File: rtl/sysins_trap_pkg.sv
package sysins_trap_pkg;

    localparam int OP_W   = 4;
    localparam int PRIV_W = 2;
    localparam int EXC_W  = 2;
    localparam int IDX_W  = 3;
    localparam int MODE_W = IDX_W - 1;

    localparam logic [OP_W-1:0] OPC_NONE      = 4'd0;
    localparam logic [OP_W-1:0] OPC_WAIT_IRQ  = 4'd1;
    localparam logic [OP_W-1:0] OPC_WAIT_RSV  = 4'd2;
    localparam logic [OP_W-1:0] OPC_XLAT_FNC  = 4'd3;
    localparam logic [OP_W-1:0] OPC_HFNC_GVA  = 4'd4;
    localparam logic [OP_W-1:0] OPC_HFNC_GPA  = 4'd5;
    localparam logic [OP_W-1:0] OPC_HLOAD     = 4'd6;
    localparam logic [OP_W-1:0] OPC_HSTORE    = 4'd7;
    localparam logic [OP_W-1:0] OPC_HLOAD_X   = 4'd8;

    localparam logic [PRIV_W-1:0] LVL_USER = 2'd0;
    localparam logic [PRIV_W-1:0] LVL_SUP  = 2'd1;
    localparam logic [PRIV_W-1:0] LVL_MACH = 2'd3;

    localparam logic [MODE_W-1:0] MODE_USER    = 2'd0;
    localparam logic [MODE_W-1:0] MODE_SUP     = 2'd1;
    localparam logic [MODE_W-1:0] MODE_SUP_SUM = 2'd2;

    typedef enum logic [EXC_W-1:0] {
        EXC_NONE    = 2'd0,
        EXC_ILLEGAL = 2'd1,
        EXC_VIRT    = 2'd2
    } exc_e;

    typedef struct packed {
        exc_e             exc;
        logic             halt;
        logic             flush;
        logic [IDX_W-1:0] idx;
    } verdict_t;

    localparam verdict_t VERDICT_IDLE = '{exc: EXC_NONE, halt: 1'b0, flush: 1'b0, idx: '0};

endpackage

// File: rtl/sysins_wait_chk.sv
module sysins_wait_chk
    import sysins_trap_pkg::*;
(
    input  logic              sel_irq,
    input  logic              sel_rsv,
    input  logic [PRIV_W-1:0] priv,
    input  logic              virt,
    input  logic              has_smode,
    input  logic              tw,
    input  logic              vtw,
    output verdict_t          verdict
);

    logic is_user;
    logic is_sup;
    logic below_mach;

    assign is_user    = (priv == LVL_USER);
    assign is_sup     = (priv == LVL_SUP);
    assign below_mach = (priv != LVL_MACH);

    always_comb begin
        verdict = VERDICT_IDLE;
        if (sel_irq) begin
            // illegal-instruction conditions take precedence over the guest ones
            if ((tw && (is_sup || (!has_smode && is_user))) ||
                (has_smode && is_user && !virt)) begin
                verdict.exc = EXC_ILLEGAL;
            end else if (virt && (is_user || (is_sup && vtw))) begin
                verdict.exc = EXC_VIRT;
            end else begin
                verdict.halt = 1'b1;
            end
        end else if (sel_rsv) begin
            // guest trap is resolved before the machine-level one here
            if (virt && (is_user || is_sup) && vtw && !tw) begin
                verdict.exc = EXC_VIRT;
            end else if (below_mach && tw) begin
                verdict.exc = EXC_ILLEGAL;
            end
        end
    end

endmodule

// File: rtl/sysins_fence_chk.sv
module sysins_fence_chk
    import sysins_trap_pkg::*;
(
    input  logic              sel_xlat,
    input  logic              sel_gva,
    input  logic              sel_gpa,
    input  logic [PRIV_W-1:0] priv,
    input  logic              virt,
    input  logic              tvm,
    input  logic              vtvm,
    output verdict_t          verdict
);

    logic is_user;
    logic is_sup;
    logic is_mach;
    logic host_sup;

    assign is_user  = (priv == LVL_USER);
    assign is_sup   = (priv == LVL_SUP);
    assign is_mach  = (priv == LVL_MACH);
    assign host_sup = is_sup && !virt;

    always_comb begin
        verdict = VERDICT_IDLE;
        if (sel_xlat) begin
            if (!virt && (is_user || (is_sup && tvm))) begin
                verdict.exc = EXC_ILLEGAL;
            end else if (virt && (is_user || vtvm)) begin
                verdict.exc = EXC_VIRT;
            end else begin
                verdict.flush = 1'b1;
            end
        end else if (sel_gva || sel_gpa) begin
            if (sel_gpa && host_sup && tvm) begin
                verdict.exc = EXC_ILLEGAL;
            end else if (virt) begin
                verdict.exc = EXC_VIRT;
            end else if (is_mach || host_sup) begin
                verdict.flush = 1'b1;
            end else begin
                verdict.exc = EXC_ILLEGAL;
            end
        end
    end

endmodule

// File: rtl/sysins_hacc_chk.sv
module sysins_hacc_chk
    import sysins_trap_pkg::*;
(
    input  logic              sel_data,
    input  logic              sel_exec,
    input  logic [PRIV_W-1:0] priv,
    input  logic              virt,
    input  logic              hu,
    input  logic              spvp,
    input  logic              vs_sum,
    output verdict_t          verdict
);

    logic [MODE_W-1:0] mode;

    always_comb begin
        mode = spvp ? MODE_SUP : MODE_USER;
        if (sel_data && spvp && vs_sum) begin
            mode = MODE_SUP_SUM;
        end
    end

    always_comb begin
        verdict = VERDICT_IDLE;
        if (sel_data || sel_exec) begin
            verdict.idx = {1'b1, mode};
            if (priv == LVL_MACH) begin
                verdict.exc = EXC_NONE;
            end else if (virt) begin
                verdict.exc = EXC_VIRT;
            end else if ((priv == LVL_USER) && !hu) begin
                verdict.exc = EXC_ILLEGAL;
            end
        end
    end

endmodule

// File: rtl/sysins_trap_chk.sv
module sysins_trap_chk
    import sysins_trap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OP_W-1:0]   op_class,
    input  logic [PRIV_W-1:0] priv,
    input  logic              virt,
    input  logic              has_smode,
    input  logic              tw,
    input  logic              tvm,
    input  logic              vtw,
    input  logic              vtvm,
    input  logic              hu,
    input  logic              spvp,
    input  logic              vs_sum,
    output logic [EXC_W-1:0]  exc,
    output logic              halt_req,
    output logic              flush_req,
    output logic [IDX_W-1:0]  xlat_idx
);

    verdict_t wait_v;
    verdict_t fence_v;
    verdict_t hacc_v;
    verdict_t res_d;
    verdict_t res_q;

    logic sel_irq, sel_rsv, sel_xlat, sel_gva, sel_gpa, sel_data, sel_exec;

    assign sel_irq  = (op_class == OPC_WAIT_IRQ);
    assign sel_rsv  = (op_class == OPC_WAIT_RSV);
    assign sel_xlat = (op_class == OPC_XLAT_FNC);
    assign sel_gva  = (op_class == OPC_HFNC_GVA);
    assign sel_gpa  = (op_class == OPC_HFNC_GPA);
    assign sel_data = (op_class == OPC_HLOAD) || (op_class == OPC_HSTORE);
    assign sel_exec = (op_class == OPC_HLOAD_X);

    sysins_wait_chk i_wait (
        .sel_irq   (sel_irq),
        .sel_rsv   (sel_rsv),
        .priv      (priv),
        .virt      (virt),
        .has_smode (has_smode),
        .tw        (tw),
        .vtw       (vtw),
        .verdict   (wait_v)
    );

    sysins_fence_chk i_fence (
        .sel_xlat (sel_xlat),
        .sel_gva  (sel_gva),
        .sel_gpa  (sel_gpa),
        .priv     (priv),
        .virt     (virt),
        .tvm      (tvm),
        .vtvm     (vtvm),
        .verdict  (fence_v)
    );

    sysins_hacc_chk i_hacc (
        .sel_data (sel_data),
        .sel_exec (sel_exec),
        .priv     (priv),
        .virt     (virt),
        .hu       (hu),
        .spvp     (spvp),
        .vs_sum   (vs_sum),
        .verdict  (hacc_v)
    );

    always_comb begin
        res_d = VERDICT_IDLE;
        if (sel_irq || sel_rsv) begin
            res_d = wait_v;
        end else if (sel_xlat || sel_gva || sel_gpa) begin
            res_d = fence_v;
        end else if (sel_data || sel_exec) begin
            res_d = hacc_v;
        end
        // a trapping instruction never issues its side request
        if (res_d.exc != EXC_NONE) begin
            res_d.halt  = 1'b0;
            res_d.flush = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= VERDICT_IDLE;
        end else begin
            res_q <= res_d;
        end
    end

    assign exc       = res_q.exc;
    assign halt_req  = res_q.halt;
    assign flush_req = res_q.flush;
    assign xlat_idx  = res_q.idx;

endmodule

// File: rtl/sysins_trap_sva.sv
module sysins_trap_sva
    import sysins_trap_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [OP_W-1:0]   op_class,
    input logic [PRIV_W-1:0] priv,
    input logic              virt,
    input logic              has_smode,
    input logic              tw,
    input logic              tvm,
    input logic              vtw,
    input logic              vtvm,
    input logic              hu,
    input logic              spvp,
    input logic              vs_sum,
    input logic [EXC_W-1:0]  exc,
    input logic              halt_req,
    input logic              flush_req,
    input logic [IDX_W-1:0]  xlat_idx
);

    logic hacc_op;
    assign hacc_op = (op_class == OPC_HLOAD) || (op_class == OPC_HSTORE) ||
                     (op_class == OPC_HLOAD_X);

    p_wait_user_host_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_class == OPC_WAIT_IRQ && has_smode && priv == LVL_USER && !virt)
        |=> (exc == EXC_ILLEGAL));

    p_halt_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_class != OPC_WAIT_IRQ) |=> !halt_req);

    p_xlat_guest_user_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_class == OPC_XLAT_FNC && priv == LVL_USER && virt)
        |=> (exc == EXC_VIRT));

    p_hfence_guest_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((op_class == OPC_HFNC_GVA) && virt) |=> (exc == EXC_VIRT));

    p_hacc_mach_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (hacc_op && priv == LVL_MACH) |=> (exc == EXC_NONE));

    p_stage_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hacc_op |=> xlat_idx[IDX_W-1]);

    p_unused_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_class == OPC_NONE || op_class > OPC_HLOAD_X)
        |=> (exc == EXC_NONE && !halt_req && !flush_req && xlat_idx == '0));

    p_no_req_on_trap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (exc != EXC_NONE) |-> (!halt_req && !flush_req));

endmodule

bind sysins_trap_chk sysins_trap_sva i_sva (.*);

// File: tb/test_sysins_trap_chk.sv
module test_sysins_trap_chk;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] op_class;
    logic [1:0] priv;
    logic       virt, has_smode, tw, tvm, vtw, vtvm, hu, spvp, vs_sum;
    logic [1:0] exc;
    logic       halt_req, flush_req;
    logic [2:0] xlat_idx;

    int tests  = 0;
    int failed = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sysins_trap_chk i_sysins_trap_chk (
        .clk(clk), .rst_n(rst_n), .op_class(op_class), .priv(priv), .virt(virt),
        .has_smode(has_smode), .tw(tw), .tvm(tvm), .vtw(vtw), .vtvm(vtvm),
        .hu(hu), .spvp(spvp), .vs_sum(vs_sum), .exc(exc), .halt_req(halt_req),
        .flush_req(flush_req), .xlat_idx(xlat_idx)
    );

    // expected result packed as {exc[1:0], halt, flush, idx[2:0]}
    function automatic logic [6:0] model(input int op, input int pl, input logic [8:0] c);
        logic v, hs, t_w, t_vm, v_tw, v_tvm, h_u, sp, sm;
        int e; logic h, f; int ix;
        {v, hs, t_w, t_vm, v_tw, v_tvm, h_u, sp, sm} = c;
        e = 0; h = 0; f = 0; ix = 0;
        case (op)
            1: begin
                if (t_w && pl == 1) e = 1;
                else if (t_w && pl == 0 && !hs) e = 1;
                else if (hs && pl == 0 && !v) e = 1;
                else if (v && pl == 0) e = 2;
                else if (v && pl == 1 && v_tw) e = 2;
                else h = 1;
            end
            2: begin
                if (v && pl != 3 && v_tw && !t_w) e = 2;
                else if (pl != 3 && t_w) e = 1;
            end
            3: begin
                if (!v) begin
                    if (pl == 0 || (pl == 1 && t_vm)) e = 1; else f = 1;
                end else begin
                    if (pl == 0 || v_tvm) e = 2; else f = 1;
                end
            end
            4, 5: begin
                if (op == 5 && pl == 1 && !v && t_vm) e = 1;
                else if (v) e = 2;
                else if (pl == 3 || pl == 1) f = 1;
                else e = 1;
            end
            6, 7, 8: begin
                ix = 4 + (sp ? 1 : 0);
                if (op != 8 && sp && sm) ix = 6;
                if (pl == 3) e = 0;
                else if (v) e = 2;
                else if (pl == 0 && !h_u) e = 1;
            end
            default: ;
        endcase
        return {e[1:0], h, f, ix[2:0]};
    endfunction

    function automatic string tag_of(input int op);
        case (op)
            1: return "R2 R3 R10";
            2: return "R4 R10";
            3: return "R5 R10";
            4, 5: return "R6 R10";
            6, 7, 8: return "R7 R8 R10";
            default: return "R9";
        endcase
    endfunction

    task automatic check(input string tag, input logic [6:0] expv);
        logic [6:0] act;
        act = {exc, halt_req, flush_req, xlat_idx};
        tests++;
        if (act !== expv) begin
            failed++;
            $display("FAIL %s: got exc=%0d halt=%0b flush=%0b idx=%0d, expected exc=%0d halt=%0b flush=%0b idx=%0d",
                     tag, act[6:5], act[4], act[3], act[2:0], expv[6:5], expv[4], expv[3], expv[2:0]);
        end
    endtask

    task automatic drive(input int op, input int pl, input logic [8:0] c);
        op_class = op[3:0];
        priv     = pl[1:0];
        {virt, has_smode, tw, tvm, vtw, vtvm, hu, spvp, vs_sum} = c;
    endtask

    initial begin
        logic [6:0] exp_prev;
        string      tag_prev;
        bit         have_prev;
        have_prev = 1'b0;
        exp_prev  = '0;
        tag_prev  = "";
        rst_n = 1'b0;
        drive(1, 1, 9'h1FF);
        repeat (3) @(negedge clk);
        check("R1 reset", 7'd0);
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 after release", 7'd0);
        for (int op = 0; op < 16; op++) begin
            for (int p = 0; p < 3; p++) begin
                for (int c = 0; c < 512; c++) begin
                    int pl;
                    pl = (p == 2) ? 3 : p;
                    @(negedge clk);
                    if (have_prev) check(tag_prev, exp_prev);
                    drive(op, pl, c[8:0]);
                    exp_prev  = model(op, pl, c[8:0]);
                    tag_prev  = tag_of(op);
                    have_prev = 1'b1;
                end
            end
        end
        @(negedge clk);
        check(tag_prev, exp_prev);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++;
            failed++;
            $display("FAIL watchdog: got running, expected finished");
            $display("[TB] %0d tests run, %0d failed", tests, failed);
            $finish;
        end
    end

endmodule